// File: doc/BRIEF.md
# Two-Counter Performance Monitor

This block counts processor activity for profiling. It holds one 32-bit cycle counter and two 32-bit event counters. Each event counter watches one line of a vector of single-cycle event pulses from the core. An 8-bit event code picks the line, for example 0x07 for an executed instruction, 0x05 for a branch, 0x06 for a mispredicted branch, 0x0A for a data cache access or 0x0B for a data cache miss. When a counter wraps, it raises an overflow flag. Any flag whose interrupt enable is set drives the interrupt line.

A single control word holds all of the configuration and all of the status. This covers the global enable, the one-shot clear commands, the cycle prescaler select, the three interrupt enables, the three overflow flags and the two event codes. A small register bus reads and writes the control word and writes or reads each counter directly. Software typically loads a counter with a negative period, sets the enable, and handles the interrupt on wrap. It clears the flags by writing back the control word value it just read.

Top module: `perf_mon_top`

## Requirements
- R1: Register map on `bus_addr`: 0 is the control word, 1 is the cycle counter, 2 is event counter 0 and 3 is event counter 1. `bus_rdata` is registered: the value sampled at a clock edge is the register at `bus_addr` as it stood just before that edge. It is 0 after reset.
- R2: No counter changes unless control bit 0 (enable) is 1, except through a bus write or a clear command.
- R3: With enable set and control bit 3 clear, the cycle counter increases by one on every clock.
- R4: With control bit 3 set, the cycle counter increases once every 64 clocks. A 6-bit prescaler runs while enabled, and the counter steps on the clock where the prescaler is 63. The prescaler is cleared by the cycle-counter clear command.
- R5: Event counter 0 takes its code from control bits 19:12 and event counter 1 from bits 27:20. While enabled, a counter adds one on each clock where `events[code]` is 1.
- R6: Code 0xFF marks a counter as unused and it never counts. Any code not below the width of `events` also never counts.
- R7: Writing 1 to control bit 1 clears both event counters. Writing 1 to control bit 2 clears the cycle counter and the prescaler. Both bits act only on that write and always read back as 0.
- R8: A bus write to a counter loads the written value. A write takes priority over an increment on the same clock.
- R9: A counter stepping past 0xFFFFFFFF becomes 0 and, on that same clock, sets its overflow flag. The flags are bit 8 for event counter 0, bit 9 for event counter 1 and bit 10 for the cycle counter.
- R10: The overflow flags are write-one-to-clear. Writing 0 to a flag leaves it unchanged, and a hardware set wins over a clear on the same clock.
- R11: Control bits 7, 11 and 31:28 always read as 0, whatever is written to them.
- R12: `irq` is registered and is 1 one clock after any flag is set together with its enable. The enables are bit 4 for event counter 0, bit 5 for event counter 1 and bit 6 for the cycle counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| events | input | NUM_EVT | Single-cycle event pulses from the core |
| irq | output | 1 | Overflow interrupt |

## Verification
Overflow is the hardest case to reach from the ports: counting up from zero would take four billion clocks. The stimulus therefore loads a counter to within one or two steps of the top through the bus, enables counting for a precisely counted number of edges, and then stops it. The wrap, the flag and the delayed interrupt can then be read back at known cycles. The divided cycle mode is reached the same way. The prescaler is cleared in the same write that enables counting, so the tick edges fall at computed positions.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;
  localparam int DATA_W    = 32;
  localparam int CODE_W    = 8;
  localparam logic [CODE_W-1:0] CODE_NONE = 8'hFF;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_CYC  = 2'd1,
    REG_EV0  = 2'd2,
    REG_EV1  = 2'd3
  } reg_sel_e;

  // control word bit positions
  localparam int B_EN     = 0;
  localparam int B_EVCLR  = 1;
  localparam int B_CYCLR  = 2;
  localparam int B_DIV    = 3;
  localparam int B_IE_LO  = 4;   // ie[0]=ev0, ie[1]=ev1, ie[2]=cyc
  localparam int B_OV_LO  = 8;   // same order as ie
  localparam int B_SEL0   = 12;
  localparam int B_SEL1   = 20;
endpackage

// File: rtl/pm_ctrl.sv
module pm_ctrl
  import perfmon_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [2:0]        ovf_set,
  output logic              en,
  output logic              div,
  output logic [2:0]        ie,
  output logic [2:0]        ovf,
  output logic [CODE_W-1:0] sel0,
  output logic [CODE_W-1:0] sel1,
  output logic              ev_clr,
  output logic              cyc_clr,
  output logic [DATA_W-1:0] word
);
  logic [2:0] w1c;
  logic       unused_bits;

  assign unused_bits = ^{wdata[7], wdata[11], wdata[31:28]};
  assign ev_clr  = wr & wdata[B_EVCLR];
  assign cyc_clr = wr & wdata[B_CYCLR];
  assign w1c     = wr ? wdata[B_OV_LO +: 3] : 3'b000;

  always_ff @(posedge clk) begin
    if (rst) begin
      en   <= 1'b0;
      div  <= 1'b0;
      ie   <= '0;
      ovf  <= '0;
      sel0 <= '0;
      sel1 <= '0;
    end else begin
      if (wr) begin
        en   <= wdata[B_EN];
        div  <= wdata[B_DIV];
        ie   <= wdata[B_IE_LO +: 3];
        sel0 <= wdata[B_SEL0 +: CODE_W];
        sel1 <= wdata[B_SEL1 +: CODE_W];
      end
      ovf <= (ovf & ~w1c) | ovf_set;
    end
  end

  assign word = {4'b0000, sel1, sel0, 1'b0, ovf, 1'b0, ie, div, 2'b00, en};
endmodule

// File: rtl/pm_counter.sv
module pm_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  assign wrap = inc & ~ld & ~clr & (&cnt);

  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (ld)  cnt <= ld_val;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pm_event_sel.sv
module pm_event_sel #(
  parameter int NUM_EVT = 32,
  parameter int CODE_W  = 8
) (
  input  logic [NUM_EVT-1:0] events,
  input  logic [CODE_W-1:0]  code,
  output logic               hit
);
  localparam int IDX_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;
  localparam logic [CODE_W-1:0] NONE = '1;

  always_comb begin
    hit = 1'b0;
    if (code != NONE && int'(code) < NUM_EVT)
      hit = events[code[IDX_W-1:0]];
  end
endmodule

// File: rtl/perf_mon_top.sv
module perf_mon_top
  import perfmon_pkg::*;
#(
  parameter int NUM_EVT  = 32,
  parameter int DIV_LOG2 = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         bus_addr,
  input  logic               bus_wr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NUM_EVT-1:0] events,
  output logic               irq
);
  localparam int NUM_EC = 2;

  logic              ctrl_en, ctrl_div, ev_clr, cyc_clr;
  logic [2:0]        ctrl_ie, ctrl_ovf, ovf_set;
  logic [CODE_W-1:0] ev_code [NUM_EC];
  logic [DATA_W-1:0] ctrl_word, cyc_cnt;
  logic [DATA_W-1:0] ev_cnt  [NUM_EC];
  logic [NUM_EC-1:0] ev_wrap;
  logic              cyc_wrap, cyc_tick;
  logic [DIV_LOG2-1:0] presc;

  pm_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .wr(bus_wr && bus_addr == REG_CTRL),
    .wdata(bus_wdata), .ovf_set(ovf_set),
    .en(ctrl_en), .div(ctrl_div), .ie(ctrl_ie), .ovf(ctrl_ovf),
    .sel0(ev_code[0]), .sel1(ev_code[1]),
    .ev_clr(ev_clr), .cyc_clr(cyc_clr), .word(ctrl_word)
  );

  always_ff @(posedge clk) begin
    if (rst || cyc_clr) presc <= '0;
    else if (ctrl_en)   presc <= presc + 1'b1;
  end

  assign cyc_tick = ctrl_en & (~ctrl_div | (&presc));

  pm_counter #(.W(DATA_W)) u_cyc (
    .clk(clk), .rst(rst), .clr(cyc_clr),
    .ld(bus_wr && bus_addr == REG_CYC), .ld_val(bus_wdata),
    .inc(cyc_tick), .cnt(cyc_cnt), .wrap(cyc_wrap)
  );

  for (genvar g = 0; g < NUM_EC; g++) begin : g_ev
    logic hit;
    pm_event_sel #(.NUM_EVT(NUM_EVT), .CODE_W(CODE_W)) u_sel (
      .events(events), .code(ev_code[g]), .hit(hit)
    );
    pm_counter #(.W(DATA_W)) u_cnt (
      .clk(clk), .rst(rst), .clr(ev_clr),
      .ld(bus_wr && bus_addr == 2'(int'(REG_EV0) + g)), .ld_val(bus_wdata),
      .inc(ctrl_en & hit), .cnt(ev_cnt[g]), .wrap(ev_wrap[g])
    );
  end

  assign ovf_set = {cyc_wrap, ev_wrap};

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      irq <= |(ctrl_ovf & ctrl_ie);
      unique case (bus_addr)
        REG_CTRL: bus_rdata <= ctrl_word;
        REG_CYC:  bus_rdata <= cyc_cnt;
        REG_EV0:  bus_rdata <= ev_cnt[0];
        default:  bus_rdata <= ev_cnt[1];
      endcase
    end
  end
endmodule

// File: rtl/perf_mon_chk.sv
module perf_mon_chk (
  input logic        clk,
  input logic        rst,
  input logic        bus_wr,
  input logic        irq,
  input logic        en,
  input logic        div,
  input logic [2:0]  ie,
  input logic [2:0]  ovf,
  input logic [7:0]  sel0,
  input logic [31:0] word,
  input logic [31:0] cyc,
  input logic [31:0] ev0
);
  // R12
  irq_delay_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq == $past(|(ovf & ie)));
  // R2
  hold_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !bus_wr) |=> $stable(cyc) && $stable(ev0));
  // R9
  cyc_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !div && !bus_wr && cyc == 32'hFFFF_FFFF) |=> (cyc == 32'd0) && ovf[2]);
  // R6
  unused_code_chk: assert property (@(posedge clk) disable iff (rst)
    (en && sel0 == 8'hFF && !bus_wr) |=> $stable(ev0));
  // R7 R11
  zero_bits_chk: assert property (@(posedge clk) disable iff (rst)
    word[2:1] == 2'b00 && word[7] == 1'b0 && word[11] == 1'b0 && word[31:28] == 4'h0);
endmodule

bind perf_mon_top perf_mon_chk u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .irq(irq),
  .en(ctrl_en), .div(ctrl_div), .ie(ctrl_ie), .ovf(ctrl_ovf),
  .sel0(ev_code[0]), .word(ctrl_word), .cyc(cyc_cnt), .ev0(ev_cnt[0])
);

// File: tb/perf_mon_top_test.sv
module perf_mon_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_EVT = 32;

  logic clk = 0, rst = 1, bus_wr = 0, irq;
  logic [1:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata, rd;
  logic [NUM_EVT-1:0] events = '0;
  int checks = 0, errors = 0;

  perf_mon_top #(.NUM_EVT(NUM_EVT)) uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .events(events), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] cw(bit en, bit evc, bit cyc, bit dv,
                                     logic [2:0] ie, logic [2:0] w1c,
                                     logic [7:0] s0, logic [7:0] s1);
    return {4'h0, s1, s0, 1'b0, w1c, 1'b0, ie, dv, cyc, evc, en};
  endfunction

  task automatic wr(logic [1:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(posedge clk); #1;
    bus_wr = 0;
  endtask

  task automatic rdreg(logic [1:0] a, output logic [31:0] v);
    bus_addr = a;
    @(posedge clk); #1;
    v = bus_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    check("R1 reset rdata", bus_rdata, 32'h0);
    check("R12 reset irq", {31'h0, irq}, 32'h0);
    rdreg(0, rd); check("R1 ctrl after reset", rd, 32'h0);
    rdreg(1, rd); check("R1 cyc after reset", rd, 32'h0);
  endtask

  task automatic t_cycle;
    wr(0, cw(1,1,1,0,0,0,0,0));
    idle(20);
    wr(0, 0);
    rdreg(1, rd); check("R3 cycle count", rd, 32'd21);
    idle(5);
    rdreg(1, rd); check("R2 held while disabled", rd, 32'd21);
  endtask

  task automatic t_div;
    wr(0, cw(1,0,1,1,0,0,0,0));
    idle(200);
    wr(0, 0);
    rdreg(1, rd); check("R4 divided cycle count", rd, 32'd3);
  endtask

  task automatic t_events;
    wr(0, cw(1,1,0,0,0,0,8'h07,8'h05));
    for (int i = 0; i < 10; i++) begin
      events = '0;
      events[7] = 1'b1;
      events[5] = (i % 2 == 0);
      idle(1);
    end
    events = '0;
    wr(0, cw(0,0,0,0,0,0,8'h07,8'h05));
    rdreg(2, rd); check("R5 ev0 instructions", rd, 32'd10);
    rdreg(3, rd); check("R5 ev1 branches", rd, 32'd5);
  endtask

  task automatic t_unused;
    wr(0, cw(1,1,0,0,0,0,8'hFF,8'h40));
    events = '1;
    idle(5);
    events = '0;
    wr(0, 0);
    rdreg(2, rd); check("R6 code FF no count", rd, 32'd0);
    rdreg(3, rd); check("R6 out-of-range code no count", rd, 32'd0);
  endtask

  task automatic t_load_clear;
    wr(2, 32'h1234_5678);
    wr(3, 32'hCAFE_F00D);
    wr(1, 32'h0BAD_BEEF);
    rdreg(2, rd); check("R8 load ev0", rd, 32'h1234_5678);
    rdreg(3, rd); check("R8 load ev1", rd, 32'hCAFE_F00D);
    wr(0, cw(1,0,0,0,0,0,0,0));
    wr(1, 32'd100);
    wr(0, 0);
    rdreg(1, rd); check("R8 write beats increment", rd, 32'd101);
    wr(0, cw(0,1,0,0,0,0,0,0));
    rdreg(2, rd); check("R7 ev clear ev0", rd, 32'd0);
    rdreg(3, rd); check("R7 ev clear ev1", rd, 32'd0);
    rdreg(1, rd); check("R7 ev clear leaves cyc", rd, 32'd101);
    rdreg(0, rd); check("R7 clear bits read 0", rd, 32'd0);
    wr(0, cw(0,0,1,0,0,0,0,0));
    rdreg(1, rd); check("R7 cyc clear", rd, 32'd0);
  endtask

  task automatic t_overflow;
    wr(1, 32'hFFFF_FFFE);
    wr(0, cw(1,0,0,0,3'b100,0,0,0));
    idle(1);
    wr(0, cw(0,0,0,0,3'b100,0,0,0));
    rdreg(0, rd); check("R9 cyc flag set, R10 write 0 keeps", rd, 32'h0000_0440);
    check("R12 irq raised", {31'h0, irq}, 32'h1);
    rdreg(1, rd); check("R9 cyc wrapped to 0", rd, 32'h0);
    wr(0, cw(0,0,0,0,3'b100,3'b100,0,0));
    rdreg(0, rd); check("R10 flag cleared", rd, 32'h0000_0040);
    check("R12 irq dropped", {31'h0, irq}, 32'h0);
    wr(2, 32'hFFFF_FFFF);
    events[10] = 1'b1;
    wr(0, cw(1,0,0,0,0,0,8'h0A,0));
    wr(0, cw(0,0,0,0,0,0,8'h0A,0));
    events = '0;
    rdreg(0, rd); check("R9 ev0 flag", rd, 32'h0000_A100);
    check("R12 irq masked", {31'h0, irq}, 32'h0);
    rdreg(2, rd); check("R9 ev0 wrapped", rd, 32'h0);
    wr(0, cw(0,0,0,0,0,3'b001,0,0));
    rdreg(0, rd); check("R10 ev0 flag cleared", rd, 32'h0);
  endtask

  task automatic t_zero_bits;
    wr(0, 32'hFFFF_FFFF);
    rdreg(0, rd); check("R11 fixed-zero bits", rd, 32'h0FFF_F079);
    wr(0, 0);
  endtask

  initial begin
    fork
      begin
        idle(3);
        rst = 0;
        idle(1);
        t_reset;
        t_cycle;
        t_div;
        t_events;
        t_unused;
        t_load_clear;
        t_overflow;
        t_zero_bits;
      end
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule